// File: doc/BRIEF.md
# Retirement Stage with Colour-Based Discard

This block is the last step of a small in-order processor pipeline. Each cycle it can take one bundle from the evaluate stage. A bundle holds everything that stage worked out in parallel: the opcode, the address of the next instruction, the main arithmetic result, a store value, the base operand, a destination register and a one-bit colour tag. The block retires the instruction. Depending on the opcode, it writes the register file, writes its internal data memory, or sends a new program counter back to fetch. Some opcodes do two of these at once.

The block does not flush earlier stages. Instead it keeps a committed colour bit, which flips on every taken branch. Fetch tags new instructions with the current colour, so a bundle that carries the old colour was fetched on an abandoned path. The block takes such a bundle and drops it without any effect. Register-file writes, memory writes and redirects are reported on registered strobe outputs one cycle after acceptance. The data memory sits inside the block, so loads and swaps read it directly.

Top module: `commit_stage`

## Requirements
- R1: Synchronous active-low reset clears all three strobes (`rf_we`, `dm_we`, `br_valid`) and sets the committed colour to 0. It also sets every data-memory word to zero.
- R2: An accepted bundle with opcode 1 (ADD) writes `in_result` to register `in_dst`. This is reported on the `rf_*` outputs in the cycle after acceptance.
- R3: Opcode 2 (BAL) does two things. It writes `in_pc_next` to the link register, which is the highest register index. It also redirects to `in_result` with `br_valid` and flips the committed colour.
- R4: Opcode 3 (BNZ) redirects to `in_result` and flips the colour only when `in_opa` is non-zero. When `in_opa` is zero it has no effect at all.
- R5: Opcode 4 (LOD) loads the memory word into register `in_dst`. The address is the low address bits of `in_result` when `in_post` is 0 (pre-indexing), or of `in_opa` when `in_post` is 1 (post-indexing).
- R6: Opcode 5 (STO) writes `in_data` to memory and writes no register. The address is chosen with the same `in_post` rule as R5.
- R7: Opcode 6 (SWP) always addresses memory with the low bits of `in_result`, whatever `in_post` says. In one cycle it writes the old word to register `in_dst` and stores `in_data` at that address, so a following read sees the new word.
- R8: A valid bundle whose `in_colour` differs from the committed colour writes nothing, redirects nothing and leaves the colour unchanged.
- R9: Opcode 0 (NOP) and the unused opcode 7 are consumed and have no effect.
- R10: While `in_valid` is low the block has no effect, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A bundle is present this cycle |
| in_op | input | 3 | Opcode: 0 NOP, 1 ADD, 2 BAL, 3 BNZ, 4 LOD, 5 STO, 6 SWP |
| in_post | input | 1 | Addressing mode for LOD/STO: 1 means post-index (use operand A) |
| in_pc_next | input | W | Address of the next sequential instruction |
| in_result | input | W | Main result; also the branch target and the pre-index address |
| in_data | input | W | Value stored by STO and SWP |
| in_opa | input | W | Base operand; BNZ test value and post-index address |
| in_dst | input | log2(NREGS) | Destination register |
| in_colour | input | 1 | Colour tag of the bundle |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | log2(NREGS) | Register written |
| rf_wdata | output | W | Value written to the register |
| dm_we | output | 1 | Memory write strobe |
| dm_addr | output | log2(DEPTH) | Memory address written |
| dm_wdata | output | W | Value written to memory |
| br_valid | output | 1 | Redirect strobe for fetch |
| br_target | output | W | New program counter |
| colour | output | 1 | Current committed colour |

## Verification
The assertions assume that `in_valid`, `in_op` and `in_colour` are known at every clock edge after reset. They also assume a new bundle may arrive every cycle, with no back-pressure. The stimulus changes inputs only at the falling edge. It idles with `in_valid` low rather than leaving inputs undriven. It sends stale-colour bundles only straight after a redirect, which is where fetch would produce them.

// File: rtl/commit_pkg.sv
// Shared types for the retirement stage.
// Assumes: opcodes are 3 bits; code 7 is reserved and treated as no-op.
package commit_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ADD = 3'd1,
        OP_BAL = 3'd2,
        OP_BNZ = 3'd3,
        OP_LOD = 3'd4,
        OP_STO = 3'd5,
        OP_SWP = 3'd6,
        OP_RSV = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        WSRC_RESULT = 2'd0,
        WSRC_LINK   = 2'd1,
        WSRC_MEM    = 2'd2
    } wsrc_e;

    typedef struct packed {
        logic  reg_we;
        wsrc_e wsrc;
        logic  link_dst;
        logic  mem_we;
        logic  addr_from_a;
        logic  branch;
    } action_t;

endpackage

// File: rtl/commit_decode.sv
// Turns an opcode into the set of side effects for one retiring bundle.
// Assumes: 'live' is already qualified by valid and colour match; when it is
// low every effect is suppressed.
module commit_decode
    import commit_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   op,
    input  logic         post,
    input  logic         live,
    input  logic [W-1:0] opa,
    output action_t      act
);

    // Select the side effects for the current opcode.
    always_comb begin
        act = '0;
        if (live) begin
            case (op_e'(op))
                OP_ADD: begin
                    act.reg_we = 1'b1;
                    act.wsrc   = WSRC_RESULT;
                end
                OP_BAL: begin
                    act.reg_we   = 1'b1;
                    act.wsrc     = WSRC_LINK;
                    act.link_dst = 1'b1;
                    act.branch   = 1'b1;
                end
                OP_BNZ: begin
                    act.branch = |opa;
                end
                OP_LOD: begin
                    act.reg_we      = 1'b1;
                    act.wsrc        = WSRC_MEM;
                    act.addr_from_a = post;
                end
                OP_STO: begin
                    act.mem_we      = 1'b1;
                    act.addr_from_a = post;
                end
                OP_SWP: begin
                    act.reg_we = 1'b1;
                    act.wsrc   = WSRC_MEM;
                    act.mem_we = 1'b1;
                end
                default: act = '0;
            endcase
        end
    end

endmodule

// File: rtl/commit_dmem.sv
// Data memory: reads combinationally, writes on the clock edge.
// Assumes: one access per cycle, so a read-then-write (swap) at one address is
// indivisible; reset clears every word.
module commit_dmem #(
    parameter  int W     = 16,
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Read the addressed word in the same cycle.
    assign rdata = mem[addr];

    // Clear on reset, otherwise store on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // R7
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !$isunknown(addr)) |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/commit_colour.sv
// Holds the committed colour bit and flips it on every taken branch.
// Assumes: 'toggle' is asserted for exactly one cycle per taken branch.
module commit_colour (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    output logic colour_o
);

    // Flip the colour when a branch is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      colour_o <= 1'b0;
        else if (toggle) colour_o <= ~colour_o;
    end

    // R3
    colour_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (colour_o != $past(colour_o)));

    // R8
    colour_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle |=> $stable(colour_o));

endmodule

// File: rtl/commit_stage.sv
// Retirement stage. It takes one bundle per cycle, drops bundles whose colour
// is stale, and reports register writes, memory writes and redirects on
// registered outputs one cycle later.
// Assumes: no back-pressure; inputs are stable around the rising edge.
module commit_stage
    import commit_pkg::*;
#(
    parameter  int W        = 16,
    parameter  int NREGS    = 16,
    parameter  int DEPTH    = 16,
    localparam int RW       = $clog2(NREGS),
    localparam int AW       = $clog2(DEPTH),
    localparam int LINK_REG = NREGS - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic          in_post,
    input  logic [W-1:0]  in_pc_next,
    input  logic [W-1:0]  in_result,
    input  logic [W-1:0]  in_data,
    input  logic [W-1:0]  in_opa,
    input  logic [RW-1:0] in_dst,
    input  logic          in_colour,
    output logic          rf_we,
    output logic [RW-1:0] rf_waddr,
    output logic [W-1:0]  rf_wdata,
    output logic          dm_we,
    output logic [AW-1:0] dm_addr,
    output logic [W-1:0]  dm_wdata,
    output logic          br_valid,
    output logic [W-1:0]  br_target,
    output logic          colour
);

    logic          live;
    action_t       act;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_rdata;
    logic [W-1:0]  reg_value;

    // Accept only bundles on the committed path.
    assign live = in_valid && (in_colour == colour);

    commit_decode #(.W(W)) u_decode (
        .op   (in_op),
        .post (in_post),
        .live (live),
        .opa  (in_opa),
        .act  (act)
    );

    commit_colour u_colour (
        .clk      (clk),
        .rst_n    (rst_n),
        .toggle   (act.branch),
        .colour_o (colour)
    );

    // Use operand A for post-indexing, otherwise the main result.
    assign mem_addr = act.addr_from_a ? in_opa[AW-1:0] : in_result[AW-1:0];

    commit_dmem #(.W(W), .DEPTH(DEPTH)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (act.mem_we),
        .addr  (mem_addr),
        .wdata (in_data),
        .rdata (mem_rdata)
    );

    // Pick the value that goes to the register file.
    always_comb begin
        case (act.wsrc)
            WSRC_LINK: reg_value = in_pc_next;
            WSRC_MEM:  reg_value = mem_rdata;
            default:   reg_value = in_result;
        endcase
    end

    // Register the retirement effects for the register file, memory and fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we     <= 1'b0;
            rf_waddr  <= '0;
            rf_wdata  <= '0;
            dm_we     <= 1'b0;
            dm_addr   <= '0;
            dm_wdata  <= '0;
            br_valid  <= 1'b0;
            br_target <= '0;
        end else begin
            rf_we     <= act.reg_we;
            rf_waddr  <= act.link_dst ? RW'(LINK_REG) : in_dst;
            rf_wdata  <= reg_value;
            dm_we     <= act.mem_we;
            dm_addr   <= mem_addr;
            dm_wdata  <= in_data;
            br_valid  <= act.branch;
            br_target <= in_result;
        end
    end

    // R2
    add_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_colour == colour && in_op == 3'd1)
        |=> (rf_we && rf_waddr == $past(in_dst) && rf_wdata == $past(in_result) && !dm_we && !br_valid));

    // R3
    bal_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_colour == colour && in_op == 3'd2)
        |=> (rf_we && rf_waddr == RW'(LINK_REG) && rf_wdata == $past(in_pc_next) && br_valid));

    // R4
    bnz_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd3 && in_opa == '0)
        |=> (!br_valid && !rf_we && !dm_we));

    // R6
    sto_no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_colour == colour && in_op == 3'd5)
        |=> (dm_we && !rf_we && dm_wdata == $past(in_data)));

    // R8
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_colour != colour) |=> (!rf_we && !dm_we && !br_valid));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!rf_we && !dm_we && !br_valid));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!rf_we && !dm_we && !br_valid && !colour));

endmodule

// File: tb/commit_stage_test.sv
// Scoreboard bench: the driver task computes the expected effects of each
// bundle and queues them; the monitor compares one item per cycle.
module commit_stage_test;

    localparam int W  = 16;
    localparam int RW = 4;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [2:0]    in_op;
    logic          in_post;
    logic [W-1:0]  in_pc_next, in_result, in_data, in_opa;
    logic [RW-1:0] in_dst;
    logic          in_colour;
    logic          rf_we, dm_we, br_valid, colour;
    logic [RW-1:0] rf_waddr;
    logic [W-1:0]  rf_wdata, dm_wdata, br_target;
    logic [AW-1:0] dm_addr;

    typedef struct {
        logic          rf;
        logic [RW-1:0] ra;
        logic [W-1:0]  rd;
        logic          dm;
        logic [AW-1:0] ma;
        logic [W-1:0]  md;
        logic          br;
        logic [W-1:0]  bt;
        logic          col;
        string         req;
    } exp_t;

    exp_t         sb[$];
    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] mmem[16];
    logic         mcol;
    bit           done = 0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    commit_stage uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_post(in_post), .in_pc_next(in_pc_next), .in_result(in_result),
        .in_data(in_data), .in_opa(in_opa), .in_dst(in_dst),
        .in_colour(in_colour), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .dm_we(dm_we), .dm_addr(dm_addr),
        .dm_wdata(dm_wdata), .br_valid(br_valid), .br_target(br_target),
        .colour(colour)
    );

    function automatic exp_t blank(input string req);
        exp_t e;
        e.rf = 0; e.ra = '0; e.rd = '0;
        e.dm = 0; e.ma = '0; e.md = '0;
        e.br = 0; e.bt = '0;
        e.col = mcol; e.req = req;
        return e;
    endfunction

    // Drive one bundle and queue its expected effects.
    task automatic send(input logic [2:0] op, input logic post,
                        input logic [W-1:0] pcn, input logic [W-1:0] res,
                        input logic [W-1:0] data, input logic [W-1:0] opa,
                        input logic [RW-1:0] dst, input logic col,
                        input string req);
        exp_t          e;
        logic [AW-1:0] a;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_post = post; in_pc_next = pcn;
        in_result = res; in_data = data; in_opa = opa; in_dst = dst;
        in_colour = col;
        e = blank(req);
        a = post ? opa[AW-1:0] : res[AW-1:0];
        if (col == mcol) begin
            case (op)
                3'd1: begin e.rf = 1; e.ra = dst; e.rd = res; end
                3'd2: begin e.rf = 1; e.ra = 4'd15; e.rd = pcn;
                            e.br = 1; e.bt = res; mcol = ~mcol; end
                3'd3: if (opa != '0) begin e.br = 1; e.bt = res; mcol = ~mcol; end
                3'd4: begin e.rf = 1; e.ra = dst; e.rd = mmem[a]; end
                3'd5: begin e.dm = 1; e.ma = a; e.md = data; mmem[a] = data; end
                3'd6: begin e.rf = 1; e.ra = dst; e.rd = mmem[res[AW-1:0]];
                            e.dm = 1; e.ma = res[AW-1:0]; e.md = data;
                            mmem[res[AW-1:0]] = data; end
                default: ;
            endcase
        end
        e.col = mcol;
        sb.push_back(e);
    endtask

    // Drive an idle cycle with busy-looking inputs.
    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_op = 3'd2; in_result = 16'hFFFF; in_opa = 16'h1;
        in_colour = mcol;
        sb.push_back(blank("R10"));
    endtask

    // Monitor: compare one queued item shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                bit   ok;
                e = sb.pop_front();
                checks++;
                ok = (rf_we == e.rf) && (!e.rf || (rf_waddr == e.ra && rf_wdata == e.rd))
                  && (dm_we == e.dm) && (!e.dm || (dm_addr == e.ma && dm_wdata == e.md))
                  && (br_valid == e.br) && (!e.br || br_target == e.bt)
                  && (colour == e.col);
                if (!ok) begin
                    errors++;
                    $display("FAIL %s: got rf=%0b r%0d=%h dm=%0b [%0d]=%h br=%0b %h col=%0b; exp rf=%0b r%0d=%h dm=%0b [%0d]=%h br=%0b %h col=%0b",
                             e.req, rf_we, rf_waddr, rf_wdata, dm_we, dm_addr, dm_wdata,
                             br_valid, br_target, colour, e.rf, e.ra, e.rd, e.dm, e.ma,
                             e.md, e.br, e.bt, e.col);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mmem[i] = '0;
        mcol = 1'b0;
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_post = 1'b0;
        in_pc_next = '0; in_result = '0; in_data = '0; in_opa = '0;
        in_dst = '0; in_colour = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R1: strobes low and colour zero after reset.
        checks++;
        if (rf_we || dm_we || br_valid || colour) begin
            errors++;
            $display("FAIL R1: got rf=%0b dm=%0b br=%0b col=%0b, expected all 0",
                     rf_we, dm_we, br_valid, colour);
        end
        @(negedge clk);
        rst_n = 1'b1;

        idle();                                                               // R10
        send(3'd4, 1'b0, 16'h0, 16'h0003, 16'h0, 16'h0, 4'd1, 1'b0, "R1");   // R1: memory zeroed
        send(3'd1, 1'b0, 16'h0, 16'h1234, 16'h0, 16'h0, 4'd3, 1'b0, "R2");
        send(3'd1, 1'b1, 16'h0, 16'hBEEF, 16'h0, 16'h9, 4'd0, 1'b0, "R2");
        send(3'd5, 1'b0, 16'h0, 16'h0005, 16'hAAAA, 16'h0007, 4'd0, 1'b0, "R6");
        send(3'd5, 1'b1, 16'h0, 16'h0009, 16'hBBBB, 16'h0007, 4'd0, 1'b0, "R6");
        send(3'd4, 1'b0, 16'h0, 16'h0007, 16'h0, 16'h0005, 4'd2, 1'b0, "R5");
        send(3'd4, 1'b1, 16'h0, 16'h0007, 16'h0, 16'h0005, 4'd6, 1'b0, "R5");
        send(3'd6, 1'b1, 16'h0, 16'h0005, 16'h5555, 16'h0007, 4'd4, 1'b0, "R7");
        send(3'd4, 1'b0, 16'h0, 16'h0005, 16'h0, 16'h0, 4'd8, 1'b0, "R7");
        send(3'd0, 1'b0, 16'h0, 16'h0005, 16'h7777, 16'h0001, 4'd5, 1'b0, "R9");
        send(3'd7, 1'b0, 16'h0, 16'h0005, 16'h7777, 16'h0001, 4'd5, 1'b0, "R9");
        send(3'd3, 1'b0, 16'h0, 16'h0040, 16'h0, 16'h0000, 4'd0, 1'b0, "R4");
        send(3'd3, 1'b0, 16'h0, 16'h0040, 16'h0, 16'h0003, 4'd0, 1'b0, "R4");
        send(3'd1, 1'b0, 16'h0, 16'h4444, 16'h0, 16'h0, 4'd9, 1'b0, "R8");
        send(3'd5, 1'b0, 16'h0, 16'h0005, 16'h9999, 16'h0, 4'd0, 1'b0, "R8");
        send(3'd2, 1'b0, 16'h0, 16'h00A0, 16'h0, 16'h1, 4'd0, 1'b0, "R8");
        send(3'd4, 1'b0, 16'h0, 16'h0005, 16'h0, 16'h0, 4'd10, 1'b1, "R8");
        send(3'd2, 1'b0, 16'h0041, 16'h0080, 16'h0, 16'h0, 4'd3, 1'b1, "R3");
        send(3'd1, 1'b0, 16'h0, 16'h0102, 16'h0, 16'h0, 4'd11, 1'b0, "R3");
        idle();                                                               // R10
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule